// File: doc/BRIEF.md
# Auxiliary UART register front-end

This block sits between a processor's register bus and a minimal serial data path. Incoming bytes arrive as an 8-bit valid/ready handshake and are held in a circular receive queue until software reads them. Writing the data register sends a byte out as a one-cycle strobe. A small interrupt unit combines the two enable bits with the queue state to drive one interrupt line, and an identify register tells software which source to service.

The bus side is a word-offset interface: `rd_en` returns read data combinationally in the same cycle, and any side effect of the access (a dequeue, an enable update, a queue flush) takes effect at the closing clock edge. Offsets: 0 data, 1 interrupt enable, 2 interrupt identify (read) / queue control (write), 3 control, 4 extended status. Other offsets read zero and ignore writes.

Top module: `aux_uart_regs`

## Requirements
- R1: After reset the receive queue is empty, both enable bits are clear, `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: Bytes read from offset 0 come out in arrival order, including when the read and write positions wrap past the last queue slot.
- R3: With DEPTH (default 8) bytes held, `rx_ready` is low and a byte offered on `rx_valid` is not stored.
- R4: A read of offset 0 while the queue is empty leaves the fill count at zero and does not disturb the order of later bytes.
- R5: A write to offset 0 raises `tx_valid` in the next cycle for exactly one cycle, with `tx_data` equal to the written byte.
- R6: A write to offset 1 keeps only bit 0 (TX enable) and bit 1 (RX enable); a read of offset 1 returns 0xC0 ORed with those two bits.
- R7: The RX source is pending when bit 1 of the enables is set and the queue holds at least one byte; the TX source is pending whenever bit 0 is set; `irq` is high exactly when either is pending.
- R8: Offset 2 reads 0xC4 when RX is pending, otherwise 0xC2 when TX is pending, otherwise 0xC1; RX wins when both are pending.
- R9: Offset 3 reads 0x00000003.
- R10: Offset 4 reads 0x30E ORed with bit 0 set when the queue is non-empty, and the fill count in bits 16 and up.
- R11: A write to offset 2 with bit 1 set empties the queue, also discarding a byte accepted in the same cycle; with bit 1 clear the write has no effect.
- R12: A dequeue and an accepted byte in the same cycle leave the fill count unchanged and keep the byte order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| addr | input | 3 | Word offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle, so a dequeue and a flush cannot coincide, and that `rx_data` is only meaningful while `rx_valid` is high. The bench drives every request from tasks that raise exactly one bus strobe per cycle on the falling edge and drop it on the next, so both assumptions hold. The only cycles with two simultaneous events are the deliberate ones for R11 and R12, which pair a bus access with a byte offer, never two bus strobes.

// File: rtl/aux_uart_regs.sv
module aux_uart_regs #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]  wdata,
  output logic [31:0] rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = CW + 1;
  localparam logic [AW-1:0] OFF_DATA = AW'(0);
  localparam logic [AW-1:0] OFF_IEN  = AW'(1);
  localparam logic [AW-1:0] OFF_IID  = AW'(2);
  localparam logic [AW-1:0] OFF_CTL  = AW'(3);
  localparam logic [AW-1:0] OFF_STS  = AW'(4);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic [1:0]    ien;
  logic [SW-1:0] slot_sum;
  logic [PW-1:0] wr_slot;
  logic          pop, push, flush, tx_pend, rx_pend;
  logic [7:0]    iid;

  assign rx_ready = count < CW'(DEPTH);
  assign pop      = rd_en && addr == OFF_DATA && count != '0;
  assign flush    = wr_en && addr == OFF_IID && wdata[1];
  assign push     = rx_valid && rx_ready && !flush;
  assign slot_sum = SW'(rd_ptr) + SW'(count);
  assign wr_slot  = (slot_sum >= SW'(DEPTH)) ? PW'(slot_sum - SW'(DEPTH)) : PW'(slot_sum);

  assign rx_pend = ien[1] && count != '0;
  assign tx_pend = ien[0];
  assign irq     = rx_pend || tx_pend;
  assign iid     = 8'hC0 | (rx_pend ? 8'h04 : tx_pend ? 8'h02 : 8'h01);

  always_ff @(posedge clk) begin
    if (push) mem[wr_slot] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      count    <= '0;
      ien      <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (flush) count <= '0;
      else       count <= count + CW'(push) - CW'(pop);
      if (wr_en && addr == OFF_IEN) ien <= wdata[1:0];
      tx_valid <= wr_en && addr == OFF_DATA;
      if (wr_en && addr == OFF_DATA) tx_data <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_DATA: rdata = {24'h0, mem[rd_ptr]};
        OFF_IEN:  rdata = {24'h0, 6'b110000, ien};
        OFF_IID:  rdata = {24'h0, iid};
        OFF_CTL:  rdata = 32'h3;
        OFF_STS:  rdata = (32'(count) << 16) | 32'h30E | {31'h0, count != '0};
        default:  rdata = '0;
      endcase
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !pop && !flush) |=> count == $past(count));
  a_r12_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> count == $past(count));
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_DATA && count == '0 && !rx_valid && !wr_en) |=> count == '0);
  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  a_r5_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_DATA) |=> (tx_valid && tx_data == $past(wdata)));
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_DATA) |=> !tx_valid);
  a_r7_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[1] && count != '0) |-> irq);
  a_r8_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_IID && ien[1] && count != '0) |-> rdata == 32'hC4);
endmodule

// File: tb/aux_uart_regs_bench.sv
module aux_uart_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, rx_valid = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [31:0] rdata;
  logic rx_ready, tx_valid, irq;
  logic [7:0] tx_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic tx_seen;
  logic [7:0] tx_byte;

  always #10 clk = ~clk;

  aux_uart_regs u_aux_uart_regs (.clk, .rst_n, .rd_en, .wr_en, .addr, .wdata, .rdata,
    .rx_valid, .rx_data, .rx_ready, .tx_valid, .tx_data, .irq);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    tx_seen = tx_valid; tx_byte = tx_data;
  endtask

  task automatic offer(input logic [7:0] d, output logic rdy);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    #1 rdy = rx_ready;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic fill_is(input int n, input string req);
    logic [31:0] v;
    bus_read(3'd4, v);
    check(v[31:16] == 16'(n), req, v, 32'(n) << 16);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    check(!irq && !tx_valid && rx_ready, "R1", {irq, tx_valid, rx_ready}, 3'b001);
    bus_read(3'd1, v);
    check(v == 32'hC0, "R1", v, 32'hC0);
    bus_read(3'd4, v);
    check(v == 32'h30E, "R1", v, 32'h30E);
  endtask

  task automatic t_ctrl_enable;
    logic [31:0] v;
    bus_read(3'd3, v);
    check(v == 32'h3, "R9", v, 32'h3);
    bus_write(3'd1, 8'hFF);
    bus_read(3'd1, v);
    check(v == 32'hC3, "R6", v, 32'hC3);
    bus_write(3'd1, 8'hFE);
    bus_read(3'd1, v);
    check(v == 32'hC2, "R6", v, 32'hC2);
    bus_write(3'd1, 8'h00);
  endtask

  task automatic t_tx;
    bus_write(3'd0, 8'h5A);
    check(tx_seen && tx_byte == 8'h5A, "R5", {tx_seen, tx_byte}, {1'b1, 8'h5A});
    @(negedge clk);
    check(!tx_valid, "R5", tx_valid, 0);
    bus_write(3'd0, 8'hA5);
    check(tx_seen && tx_byte == 8'hA5, "R5", {tx_seen, tx_byte}, {1'b1, 8'hA5});
  endtask

  task automatic t_fifo_wrap;
    logic rdy;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) offer(8'h10 + 8'(i), rdy);
    for (int i = 0; i < 3; i++) begin
      bus_read(3'd0, v);
      check(v == 32'h10 + 32'(i), "R2", v, 32'h10 + 32'(i));
    end
    for (int i = 0; i < 6; i++) offer(8'h20 + 8'(i), rdy);
    #1 check(!rx_ready, "R3", rx_ready, 0);
    bus_read(3'd4, v);
    check(v == 32'h0008_030F, "R10", v, 32'h0008_030F);
    offer(8'hEE, rdy);
    check(!rdy, "R3", rdy, 0);
    fill_is(8, "R3");
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = (i < 2) ? 8'h13 + 8'(i) : 8'h20 + 8'(i - 2);
      bus_read(3'd0, v);
      check(v == 32'(e), "R2", v, 32'(e));
    end
    bus_read(3'd4, v);
    check(v == 32'h30E, "R10", v, 32'h30E);
  endtask

  task automatic t_empty_read;
    logic rdy;
    logic [31:0] v;
    bus_read(3'd0, v);
    bus_read(3'd0, v);
    fill_is(0, "R4");
    offer(8'h77, rdy);
    offer(8'h78, rdy);
    bus_read(3'd0, v);
    check(v == 32'h77, "R4", v, 32'h77);
    bus_read(3'd0, v);
    check(v == 32'h78, "R4", v, 32'h78);
  endtask

  task automatic t_irq;
    logic rdy;
    logic [31:0] v;
    bus_read(3'd2, v);
    check(v == 32'hC1 && !irq, "R8", v, 32'hC1);
    bus_write(3'd1, 8'h01);
    #1 check(irq, "R7", irq, 1);
    bus_read(3'd2, v);
    check(v == 32'hC2, "R8", v, 32'hC2);
    bus_write(3'd1, 8'h02);
    #1 check(!irq, "R7", irq, 0);
    offer(8'h31, rdy);
    #1 check(irq, "R7", irq, 1);
    bus_write(3'd1, 8'h03);
    bus_read(3'd2, v);
    check(v == 32'hC4, "R8", v, 32'hC4);
    bus_read(3'd0, v);
    bus_read(3'd2, v);
    check(v == 32'hC2, "R8", v, 32'hC2);
    bus_write(3'd1, 8'h00);
    #1 check(!irq, "R7", irq, 0);
  endtask

  task automatic t_flush;
    logic rdy;
    logic [31:0] v;
    offer(8'h41, rdy);
    offer(8'h42, rdy);
    bus_write(3'd2, 8'hFD);
    fill_is(2, "R11");
    bus_write(3'd2, 8'h02);
    fill_is(0, "R11");
    offer(8'h43, rdy);
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 8'h02; rx_valid = 1'b1; rx_data = 8'h44;
    @(negedge clk); wr_en = 1'b0; rx_valid = 1'b0;
    fill_is(0, "R11");
  endtask

  task automatic t_push_pop;
    logic rdy;
    logic [31:0] v;
    offer(8'h51, rdy);
    offer(8'h52, rdy);
    @(negedge clk); rd_en = 1'b1; addr = 3'd0; rx_valid = 1'b1; rx_data = 8'h53;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0;
    check(v == 32'h51, "R12", v, 32'h51);
    fill_is(2, "R12");
    bus_read(3'd0, v);
    check(v == 32'h52, "R12", v, 32'h52);
    bus_read(3'd0, v);
    check(v == 32'h53, "R12", v, 32'h53);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl_enable;
    t_tx;
    t_fifo_wrap;
    t_empty_read;
    t_irq;
    t_flush;
    t_push_pop;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule